// File: doc/BRIEF.md
# Quad-Line Program Command Receiver

This block is the receive front end of a serial flash slave for one program command in which the address and the data travel on four data lines at once. It works in the system clock domain. It brings the chip select, the serial clock and the four data lines through synchronizer flops and finds the rising edges of the serial clock inside the system clock. While chip select is low it shifts in an 8-bit command code on data line 0 alone. If the code matches the configured program code, it gathers the address and then the data bytes four bits per serial clock.

Each data byte is handed to a downstream program engine as a one-cycle strobe. The strobe carries the byte, its position within the command and the address captured for that command. The address is 24 or 32 bits wide, chosen by an addressing-mode input. When chip select rises in the middle of a byte, the block raises an abort pulse, and the engine uses it to reject the command. Any other command code makes the block ignore the rest of the transaction.

Top module: `quad_prog_rx`

## Requirements
- R1: While chip select is low, the first 8 serial clock rising edges each shift in one bit from data line 0, most significant bit first. The 8-bit result is compared with the parameter PROG_OPCODE (default 8'h38).
- R2: When the command code differs from PROG_OPCODE, no byte strobe and no abort pulse are produced for the rest of that transaction, whatever is clocked in.
- R3: With addr4_en low, the address takes 6 serial clocks of 4 bits each. Line 3 holds the most significant bit of each nibble and line 0 the least, and the first nibble holds address bits 23..20. cmd_addr shows the 24-bit value with the upper 8 bits zero.
- R4: With addr4_en high, the address takes 8 serial clocks and the first nibble holds bits 31..28. addr4_en is sampled once, on the 8th command-code clock, and later changes have no effect on that transaction.
- R5: After the address, every two serial clocks form one data byte: the first nibble is bits 7..4 and the second is bits 3..0. byte_vld pulses for exactly one system clock with byte_data holding the byte.
- R6: byte_idx is 0 for the first data byte of a transaction and rises by one for each later byte, wrapping modulo 2^IDX_W. cmd_addr holds the captured address with every strobe.
- R7: While chip select is high all receive state is cleared, so every transaction starts again with a command code and byte index 0.
- R8: abort_pulse is high for one system clock when chip select rises after 1 to 7 command-code clocks, after an odd number of address clocks, or after the first nibble of a data byte. It stays low when chip select rises on a byte boundary, including straight after the address.
- R9: While rst is high and after it, byte_vld, abort_pulse, byte_data, byte_idx and cmd_addr are all zero.
- R10: Data lines are sampled only at serial clock rising edges. Changes on them while the serial clock is high or low have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_in | input | 1 | Chip select from the pad, active low, asynchronous |
| sck_in | input | 1 | Serial clock from the pad, asynchronous |
| dq_in | input | 4 | Data lines from the pads, line 3 is the most significant |
| addr4_en | input | 1 | Addressing-mode flag: 1 selects 32-bit addresses |
| byte_vld | output | 1 | One-cycle strobe for a completed data byte |
| byte_data | output | 8 | Received data byte |
| byte_idx | output | IDX_W | Position of the byte within the command |
| cmd_addr | output | 32 | Address captured for the current command |
| abort_pulse | output | 1 | One-cycle flag: chip select rose in the middle of a byte |

## Verification
The hardest case to reach is chip select rising at each kind of byte-boundary point. A partial command code, an odd address count and a lone data nibble must each raise the abort pulse, while an end straight after the last address nibble must not. The bench builds these cases by driving a chosen number of serial clocks in each phase and then raising chip select. It also changes the mode flag after the command code and puts junk on the data lines while the serial clock is high, to show that neither reaches the assembled address or bytes. A 258-byte command drives the index through its wrap.

// File: rtl/qp_pkg.sv
package qp_pkg;
  typedef enum logic [1:0] {
    PH_OPC  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_IGN  = 2'd3
  } phase_t;

  localparam int OPC_BITS   = 8;
  localparam int LANES      = 4;
  localparam int ADDR_W     = 32;
  localparam int ADDR3_BITS = 24;
endpackage

// File: rtl/qp_sync.sv
module qp_sync #(
  parameter int           W       = 6,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic [W-1:0] r;
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) r <= RST_VAL;
        else     r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) r <= RST_VAL;
        else     r <= g_stg[s-1].r;
      end
    end
  end

  assign q = g_stg[STAGES-1].r;
endmodule

// File: rtl/qp_front.sv
module qp_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n_in,
  input  logic       sck_in,
  input  logic [3:0] dq_in,
  output logic       cs_hi,
  output logic       cs_rise,
  output logic       sck_rise,
  output logic [3:0] dq
);
  localparam int W = 6;
  localparam logic [W-1:0] IDLE = 6'b100000;

  logic [W-1:0] raw, synced;
  logic         cs_q, sck_q;

  assign raw = {cs_n_in, sck_in, dq_in};

  qp_sync #(.W(W), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(synced)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= synced[5];
      sck_q <= synced[4];
    end
  end

  assign cs_hi    = synced[5];
  assign cs_rise  = synced[5] & ~cs_q;
  assign sck_rise = synced[4] & ~sck_q & ~synced[5];
  assign dq       = synced[3:0];
endmodule

// File: rtl/qp_core.sv
module qp_core
  import qp_pkg::*;
#(
  parameter logic [7:0] PROG_OPCODE = 8'h38,
  parameter int         IDX_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_hi,
  input  logic              cs_rise,
  input  logic              sck_rise,
  input  logic [3:0]        dq,
  input  logic              addr4_en,
  output logic              byte_vld,
  output logic [7:0]        byte_data,
  output logic [IDX_W-1:0]  byte_idx,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              abort_pulse
);
  localparam int CLK4  = ADDR_W / LANES;
  localparam int CLK3  = ADDR3_BITS / LANES;
  localparam int CNT_W = $clog2((CLK4 > OPC_BITS) ? CLK4 : OPC_BITS);

  phase_t             phase;
  logic [CNT_W-1:0]   cnt, last_addr;
  logic [ADDR_W-1:0]  sr, addr_word;
  logic [7:0]         opc_word;
  logic [3:0]         hi_nib;
  logic               half, mode_q, partial;
  logic [IDX_W-1:0]   idx_cnt;

  always_comb begin
    last_addr = mode_q ? CNT_W'(CLK4 - 1) : CNT_W'(CLK3 - 1);
    opc_word  = {sr[6:0], dq[0]};
    addr_word = {sr[ADDR_W-LANES-1:0], dq};
    partial   = ((phase == PH_OPC)  && (cnt != '0)) ||
                ((phase == PH_ADDR) && cnt[0])      ||
                ((phase == PH_DATA) && half);
  end

  always_ff @(posedge clk) begin
    if (rst || cs_hi) begin
      phase       <= PH_OPC;
      cnt         <= '0;
      sr          <= '0;
      half        <= 1'b0;
      hi_nib      <= '0;
      idx_cnt     <= '0;
      mode_q      <= 1'b0;
      cmd_addr    <= '0;
      byte_vld    <= 1'b0;
      byte_data   <= '0;
      byte_idx    <= '0;
      abort_pulse <= !rst && cs_rise && partial;
    end else begin
      byte_vld    <= 1'b0;
      abort_pulse <= 1'b0;
      if (sck_rise) begin
        unique case (phase)
          PH_OPC: begin
            sr <= {{(ADDR_W-8){1'b0}}, opc_word};
            if (cnt == CNT_W'(OPC_BITS - 1)) begin
              cnt    <= '0;
              sr     <= '0;
              mode_q <= addr4_en;
              phase  <= (opc_word == PROG_OPCODE) ? PH_ADDR : PH_IGN;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          PH_ADDR: begin
            sr <= addr_word;
            if (cnt == last_addr) begin
              cnt      <= '0;
              cmd_addr <= addr_word;
              phase    <= PH_DATA;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          PH_DATA: begin
            if (!half) begin
              hi_nib <= dq;
              half   <= 1'b1;
            end else begin
              half      <= 1'b0;
              byte_vld  <= 1'b1;
              byte_data <= {hi_nib, dq};
              byte_idx  <= idx_cnt;
              idx_cnt   <= idx_cnt + IDX_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R5
  vld_single_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld |=> !byte_vld);

  // R8
  vld_abort_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(byte_vld && abort_pulse));

  // R2
  ign_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IGN) |=> (!byte_vld && !abort_pulse));

  // R7
  cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_hi |=> (phase == PH_OPC && !byte_vld && idx_cnt == '0));

  // R3
  addr3_len_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ADDR && !mode_q) |-> (cnt < CNT_W'(CLK3)));
endmodule

// File: rtl/quad_prog_rx.sv
module quad_prog_rx #(
  parameter logic [7:0] PROG_OPCODE = 8'h38,
  parameter int         IDX_W       = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n_in,
  input  logic             sck_in,
  input  logic [3:0]       dq_in,
  input  logic             addr4_en,
  output logic             byte_vld,
  output logic [7:0]       byte_data,
  output logic [IDX_W-1:0] byte_idx,
  output logic [31:0]      cmd_addr,
  output logic             abort_pulse
);
  logic       cs_hi, cs_rise, sck_rise;
  logic [3:0] dq;

  qp_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .cs_n_in(cs_n_in), .sck_in(sck_in), .dq_in(dq_in),
    .cs_hi(cs_hi), .cs_rise(cs_rise), .sck_rise(sck_rise), .dq(dq)
  );

  qp_core #(.PROG_OPCODE(PROG_OPCODE), .IDX_W(IDX_W)) u_core (
    .clk(clk), .rst(rst), .cs_hi(cs_hi), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .dq(dq), .addr4_en(addr4_en),
    .byte_vld(byte_vld), .byte_data(byte_data), .byte_idx(byte_idx),
    .cmd_addr(cmd_addr), .abort_pulse(abort_pulse)
  );
endmodule

// File: tb/sim_quad_prog_rx.sv
`timescale 1ns/1ps
module sim_quad_prog_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic [3:0] dq = 4'h0;
  logic       a4 = 1'b0;
  logic       byte_vld, abort_pulse;
  logic [7:0] byte_data, byte_idx;
  logic [31:0] cmd_addr;

  int checks = 0;
  int errs   = 0;
  int seen   = 0;

  typedef struct packed {
    logic        is_abort;
    logic        wide;
    logic [7:0]  data;
    logic [7:0]  idx;
    logic [31:0] addr;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  quad_prog_rx u0 (
    .clk(clk), .rst(rst), .cs_n_in(cs_n), .sck_in(sck), .dq_in(dq),
    .addr4_en(a4), .byte_vld(byte_vld), .byte_data(byte_data),
    .byte_idx(byte_idx), .cmd_addr(cmd_addr), .abort_pulse(abort_pulse)
  );

  // monitor: pops expected items as the design produces results
  always @(negedge clk) begin
    if (!rst && (byte_vld || abort_pulse)) begin
      exp_t e;
      seen++;
      checks++;
      if (q.size() == 0) begin
        errs++;
        $display("FAIL R2/R8 unexpected output vld=%0b abort=%0b expected none",
                 byte_vld, abort_pulse);
      end else begin
        e = q.pop_front();
        if (e.is_abort) begin
          if (!abort_pulse || byte_vld) begin
            errs++;
            $display("FAIL R8 abort=%0b vld=%0b expected abort=1 vld=0",
                     abort_pulse, byte_vld);
          end
        end else if (abort_pulse) begin
          errs++;
          $display("FAIL R8 abort=1 expected 0 with byte");
        end else begin
          if (byte_data !== e.data) begin
            errs++;
            $display("FAIL R5 data=%h expected %h", byte_data, e.data);
          end
          if (byte_idx !== e.idx) begin
            errs++;
            $display("FAIL R6 idx=%0d expected %0d", byte_idx, e.idx);
          end
          if (cmd_addr !== e.addr) begin
            errs++;
            if (e.wide) $display("FAIL R4 addr=%h expected %h", cmd_addr, e.addr);
            else        $display("FAIL R3 addr=%h expected %h", cmd_addr, e.addr);
          end
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial clock; junk placed on lines while sck is high (R10)
  task automatic sclk(input logic [3:0] v);
    dq = v;   tick(3);
    sck = 1'b1; tick(3);
    dq = ~v;  tick(2);
    sck = 1'b0; tick(2);
  endtask

  task automatic cs_begin();
    cs_n = 1'b0; tick(4);
  endtask

  task automatic cs_end();
    tick(8); cs_n = 1'b1; tick(14);
  endtask

  task automatic send_opc(input logic [7:0] o, input int nbits);
    for (int i = 0; i < nbits; i++) sclk({3'b101, o[7-i]});
  endtask

  task automatic send_addr(input logic [31:0] a, input bit wide, input int nclk);
    int n;
    n = wide ? 8 : 6;
    for (int i = 0; i < nclk; i++) sclk(a[(n-1-i)*4 +: 4]);
  endtask

  task automatic send_data(input logic [31:0] ea, input bit wide, input int nb,
                           input logic [7:0] seed, input bit expect_out);
    for (int i = 0; i < nb; i++) begin
      logic [7:0] d;
      exp_t e;
      d = seed + 8'(i * 37);
      e.is_abort = 1'b0; e.wide = wide; e.data = d; e.idx = 8'(i); e.addr = ea;
      if (expect_out) q.push_back(e);
      sclk(d[7:4]);
      sclk(d[3:0]);
    end
  endtask

  task automatic push_abort();
    exp_t e;
    e = '0;
    e.is_abort = 1'b1;
    q.push_back(e);
  endtask

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int s0;
    tick(5);
    // R9 reset state
    check_eq("R9 vld",   {31'b0, byte_vld}, 32'h0);
    check_eq("R9 abort", {31'b0, abort_pulse}, 32'h0);
    check_eq("R9 data",  {24'b0, byte_data}, 32'h0);
    check_eq("R9 addr",  cmd_addr, 32'h0);
    rst = 1'b0;
    tick(5);
    check_eq("R9 idle after reset", {24'b0, byte_idx} | {31'b0, byte_vld}, 32'h0);

    // R1 R3 R5 R6: 24-bit address, four bytes
    a4 = 1'b0;
    cs_begin(); send_opc(8'h38, 8); send_addr(32'h00A1B2C3, 0, 6);
    send_data(32'h00A1B2C3, 0, 4, 8'h5A, 1); cs_end();

    // R4: 32-bit address
    a4 = 1'b1;
    cs_begin(); send_opc(8'h38, 8); send_addr(32'hDEADBEEF, 1, 8);
    send_data(32'hDEADBEEF, 1, 3, 8'hC3, 1); cs_end();

    // R7: next transaction restarts index, upper address bits zero (R3)
    a4 = 1'b0;
    cs_begin(); send_opc(8'h38, 8); send_addr(32'h7F123456, 0, 6);
    send_data(32'h00123456, 0, 2, 8'h0F, 1); cs_end();

    // R4: mode flag changed after the command code has no effect
    a4 = 1'b0;
    cs_begin(); send_opc(8'h38, 8); a4 = 1'b1;
    send_addr(32'h00654321, 0, 6);
    send_data(32'h00654321, 0, 2, 8'h99, 1); cs_end();
    a4 = 1'b0;

    // R2: wrong command code, everything afterwards ignored
    s0 = seen;
    cs_begin(); send_opc(8'h32, 8); send_addr(32'h11223344, 1, 8);
    send_data(32'h0, 0, 3, 8'h44, 0); sclk(4'hA); cs_end();
    check_eq("R2 no output after wrong code", 32'(seen - s0), 32'h0);

    // R8: mid-code, mid-address, mid-data aborts
    push_abort();
    cs_begin(); send_opc(8'h38, 3); cs_end();
    push_abort();
    cs_begin(); send_opc(8'h38, 8); send_addr(32'h00ABCDEF, 0, 3); cs_end();
    cs_begin(); send_opc(8'h38, 8); send_addr(32'h00ABCDEF, 0, 6);
    send_data(32'h00ABCDEF, 0, 2, 8'h21, 1); sclk(4'h7);
    push_abort(); cs_end();

    // R8: clean end right after the address raises nothing
    s0 = seen;
    cs_begin(); send_opc(8'h38, 8); send_addr(32'h00000010, 0, 6); cs_end();
    check_eq("R8 no abort on boundary", 32'(seen - s0), 32'h0);

    // R8: end after even address count inside 32-bit mode also clean
    a4 = 1'b1; s0 = seen;
    cs_begin(); send_opc(8'h38, 8); send_addr(32'h01020304, 1, 4); cs_end();
    check_eq("R8 no abort on even address count", 32'(seen - s0), 32'h0);
    a4 = 1'b0;

    // R6: index wrap over 258 bytes
    cs_begin(); send_opc(8'h38, 8); send_addr(32'h00FFFF00, 0, 6);
    send_data(32'h00FFFF00, 0, 258, 8'h03, 1); cs_end();

    check_eq("R7 all expected items produced", 32'(q.size()), 32'h0);
    check_eq("R1 item count", 32'(seen), 32'(4+3+2+2+1+1+2+1+258));
    summary();
    $finish;
  end
endmodule